// File: doc/BRIEF.md
# Program/Erase Status Byte Generator

This block builds the byte returned to a reader while the embedded program or erase engine is working, or while an erase is parked in suspend. Each read strobe captures one byte: either a status word assembled from the engine's flags, or the plain array data that the array sense path supplies. The choice depends on the engine state and on whether the read address falls in a block that is marked for erase. The engine itself and the bus drivers sit outside this block.

The status word carries a polling bit (bit 7), which is the inverse of the bit being written or zero during erase. It also carries two read-driven toggle bits: bit 6 flips on every status read, and bit 2 flips only on reads of a block marked for erase. The remaining status fields are a failure flag (bit 5), an erase-started flag (bit 3) and reserved zeros. An erase aimed only at protected blocks produces a timed pseudo-erase window, counted in clock cycles, during which erase status is returned before reads fall back to the array.

Top module: `pe_status_gen`

## Requirements
- R1: In a run status read (engine busy or protected window), bit 7 is the inverse of `prog_bit7` for a program and 0 for an erase.
- R2: Bit 6 of a run status read inverts on every successive status read, and the first status read after `op_start` returns 0.
- R3: Bit 5 of any status read equals `op_error`.
- R4: Bit 3 of a status read equals `erase_live` during an erase, a protected window or a suspend, and is 0 during a plain program.
- R5: Bit 2 of a status read toggles (first value 0 after `op_start`) only when the read address lies in a block whose `erase_sel` bit is set during an erase or suspend. Otherwise it reads 1 and does not advance.
- R6: With `erase_susp`=1 and the engine idle, a read of a selected block returns bits 7 and 6 as 1. A read of any other block returns `array_data` unchanged.
- R7: With the engine idle, no suspend and no window, every read returns `array_data`. Bit 6 does not advance during a suspend, so it continues from its pre-suspend value on resume.
- R8: An `op_start` with `op_erase`=1, a non-zero `erase_sel` and every selected block set in `blk_prot` opens a window of `PROT_CYC` cycles. During that window reads return erase status (bit 7 = 0, bit 6 toggling); after it closes, reads return `array_data`.
- R9: Bits 4, 1 and 0 of every status read are 0.
- R10: `dout` is 0 after reset and changes only on the clock edge that samples `rd_stb`=1; it holds otherwise.
- R11: The block index of a read is the top log2(`NBLK`) bits of `rd_addr`, and block i is selected when `erase_sel[i]`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | One-cycle pulse as a new program or erase begins |
| op_busy | input | 1 | Engine is executing a program or erase |
| op_erase | input | 1 | Current operation is an erase (0 = program) |
| erase_susp | input | 1 | Erase is suspended |
| op_error | input | 1 | Operation failed |
| erase_live | input | 1 | Block-add window closed, erase has begun |
| prog_bit7 | input | 1 | Bit 7 of the data being programmed |
| erase_sel | input | NBLK | Per-block erase selection |
| blk_prot | input | NBLK | Per-block protection flags |
| rd_addr | input | AW | Read address |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| array_data | input | 8 | Array data for the current read address |
| dout | output | 8 | Captured read byte |

## Verification
A corrupted toggle flop shows as a bit 6 or bit 2 value that breaks the alternation on the very next status read, or as a non-zero first read after a start. A wrong block decode swaps array data for status (or bit 2 for a constant 1) on the first read of the affected block. A window counter that is off shows as status or array data at reads placed just inside and well outside the window, and a lost suspend hold shows on the first read after resume.

// File: rtl/pe_status_pkg.sv
// Shared types for the status byte generator.
package pe_status_pkg;
    // Which source feeds the captured read byte.
    typedef enum logic [1:0] {
        SRC_ARRAY = 2'd0,
        SRC_RUN   = 2'd1,
        SRC_SUSP  = 2'd2
    } rd_src_e;
endpackage

// File: rtl/pe_blk_hit.sv
// Block decode: reports whether the read address falls in a block selected
// for erase. Assumes equal-size blocks, NBLK a power of two, NBLK >= 2.
module pe_blk_hit #(
    parameter int AW   = 12,
    parameter int NBLK = 4
) (
    input  logic [AW-1:0]   rd_addr,
    input  logic [NBLK-1:0] erase_sel,
    output logic            hit
);
    localparam int BB = $clog2(NBLK);

    logic [NBLK-1:0] match;

    // One comparator per block against the address's top bits.
    for (genvar i = 0; i < NBLK; i++) begin : g_blk
        assign match[i] = erase_sel[i] && (rd_addr[AW-1 -: BB] == BB'(i));
    end

    // Any selected block matching the address.
    assign hit = |match;
endmodule

// File: rtl/pe_toggle_bit.sv
// Read-driven toggle flop: cleared on clr, inverted on flip, else held.
// Assumes clr has priority over flip.
module pe_toggle_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic flip,
    output logic q
);
    // Toggle state update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) q <= 1'b0;
        else if (flip)     q <= ~q;
    end

    a_r2_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !q);
    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !flip) |=> $stable(q));
endmodule

// File: rtl/pe_prot_timer.sv
// Protected-erase window: when an erase starts and every selected block is
// protected, asserts win for CYC cycles. Assumes CYC >= 1.
module pe_prot_timer #(
    parameter int NBLK = 4,
    parameter int CYC  = 5000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            erase,
    input  logic [NBLK-1:0] sel,
    input  logic [NBLK-1:0] prot,
    output logic            win
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;
    logic          arm;

    // Erase aimed only at protected blocks.
    assign arm = start && erase && (sel != '0) && ((sel & ~prot) == '0);

    // Window countdown.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (arm)        cnt <= CW'(CYC);
        else if (start)      cnt <= '0;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign win = (cnt != '0);

    a_r8_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> win);
    a_r8_window_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
        (win && !start) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/pe_status_gen.sv
// Status byte generator: on each read strobe captures either a status word
// built from engine flags and two read-driven toggle bits, or array data.
// Assumes rd_stb is a single-cycle pulse per read and op_start is not
// raised in the same cycle as rd_stb.
module pe_status_gen
    import pe_status_pkg::*;
#(
    parameter int AW       = 12,
    parameter int NBLK     = 4,
    parameter int PROT_CYC = 5000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_start,
    input  logic            op_busy,
    input  logic            op_erase,
    input  logic            erase_susp,
    input  logic            op_error,
    input  logic            erase_live,
    input  logic            prog_bit7,
    input  logic [NBLK-1:0] erase_sel,
    input  logic [NBLK-1:0] blk_prot,
    input  logic [AW-1:0]   rd_addr,
    input  logic            rd_stb,
    input  logic [7:0]      array_data,
    output logic [7:0]      dout
);
    logic    hit, win, tog6, tog2;
    logic    run, erm, dq2_live, flip6, flip2;
    rd_src_e src;
    logic [7:0] nxt;
    logic    stat_q;

    pe_blk_hit #(.AW(AW), .NBLK(NBLK)) u_hit (
        .rd_addr(rd_addr), .erase_sel(erase_sel), .hit(hit));

    pe_prot_timer #(.NBLK(NBLK), .CYC(PROT_CYC)) u_win (
        .clk(clk), .rst_n(rst_n), .start(op_start), .erase(op_erase),
        .sel(erase_sel), .prot(blk_prot), .win(win));

    pe_toggle_bit u_t6 (.clk(clk), .rst_n(rst_n), .clr(op_start),
        .flip(flip6), .q(tog6));
    pe_toggle_bit u_t2 (.clk(clk), .rst_n(rst_n), .clr(op_start),
        .flip(flip2), .q(tog2));

    assign run      = op_busy || win;
    assign erm      = win || op_erase;
    assign dq2_live = hit && (erm || erase_susp);

    // Select the source of the read byte.
    always_comb begin
        if (run)                    src = SRC_RUN;
        else if (erase_susp && hit) src = SRC_SUSP;
        else                        src = SRC_ARRAY;
    end

    // Assemble the byte for the selected source.
    always_comb begin
        unique case (src)
            SRC_RUN:  nxt = {erm ? 1'b0 : ~prog_bit7, tog6, op_error, 1'b0,
                             (erm || erase_susp) && erase_live,
                             dq2_live ? tog2 : 1'b1, 2'b00};
            SRC_SUSP: nxt = {1'b1, 1'b1, op_error, 1'b0, erase_live,
                             tog2, 2'b00};
            default:  nxt = array_data;
        endcase
    end

    assign flip6 = rd_stb && (src == SRC_RUN);
    assign flip2 = rd_stb && (src != SRC_ARRAY) && dq2_live;

    // Capture the read byte on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout   <= 8'h00;
            stat_q <= 1'b0;
        end else if (rd_stb) begin
            dout   <= nxt;
            stat_q <= (src != SRC_ARRAY);
        end
    end

    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q |-> (dout[4] == 1'b0 && dout[1:0] == 2'b00));
    a_r10_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(dout));
    a_r6_suspend_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && erase_susp && !op_busy && !win && hit) |=> (dout[7:6] == 2'b11));
    a_r8_window_erase_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && win) |=> (dout[7] == 1'b0));
endmodule

// File: tb/test_pe_status_gen.sv
module test_pe_status_gen;
    localparam int AW = 12, NBLK = 4, PC = 64, BB = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic op_start = 0, op_busy = 0, op_erase = 0, erase_susp = 0;
    logic op_error = 0, erase_live = 0, prog_bit7 = 0, rd_stb = 0;
    logic [NBLK-1:0] erase_sel = '0, blk_prot = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0] array_data = '0, dout;

    int checks = 0, errors = 0;
    logic m6 = 0, m2 = 0, m_win = 0;

    always #10 clk = ~clk;

    pe_status_gen #(.AW(AW), .NBLK(NBLK), .PROT_CYC(PC)) i_pe_status_gen (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_busy(op_busy),
        .op_erase(op_erase), .erase_susp(erase_susp), .op_error(op_error),
        .erase_live(erase_live), .prog_bit7(prog_bit7), .erase_sel(erase_sel),
        .blk_prot(blk_prot), .rd_addr(rd_addr), .rd_stb(rd_stb),
        .array_data(array_data), .dout(dout));

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    // Expected byte from the requirements, advancing the bench's toggle model.
    task automatic read_chk(input int a, input string tag);
        logic [7:0] e, arr;
        logic hit, run, erm, d2;
        arr = 8'(a * 7 + 8'h3C);
        hit = erase_sel[a >> (AW - BB)];
        run = op_busy | m_win;
        erm = m_win | op_erase;
        d2  = hit & (erm | erase_susp);
        if (run) begin
            e = {erm ? 1'b0 : ~prog_bit7, m6, op_error, 1'b0,
                 (erm | erase_susp) & erase_live, d2 ? m2 : 1'b1, 2'b00};
            m6 = ~m6;
            if (d2) m2 = ~m2;
        end else if (erase_susp && hit) begin
            e = {2'b11, op_error, 1'b0, erase_live, m2, 2'b00};
            m2 = ~m2;
        end else e = arr;
        @(negedge clk);
        rd_addr = AW'(a); array_data = arr; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        check(dout, e, tag);
    endtask

    task automatic start_op();
        @(negedge clk); op_start = 1'b1;
        @(negedge clk); op_start = 1'b0;
        m6 = 0; m2 = 0;
    endtask

    initial begin
        #4ms;
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(dout, 8'h00, "R10 reset");
        rst_n = 1'b1;

        // R7: idle reads return array data in every block.
        erase_sel = 4'b1111;
        for (int b = 0; b < NBLK; b++) read_chk(b * 1024 + 5, "R7 idle");

        // R1 R2 R3 R4 R9: program status over bit/err combinations.
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            prog_bit7 = p[0]; op_error = p[1]; op_erase = 0; erase_sel = 4'b0010;
            erase_live = 1'b1; op_busy = 1'b1;
            start_op();
            for (int b = 0; b < NBLK; b++) read_chk(b * 1024 + p, "R1 R2 R3 R4 R9 program");
        end

        // R5 R11 R2: erase over every selection mask.
        for (int s = 1; s < 16; s++) begin
            @(negedge clk);
            op_erase = 1'b1; erase_sel = 4'(s); erase_live = s[0]; op_error = s[3];
            start_op();
            for (int r = 0; r < 2; r++)
                for (int b = 0; b < NBLK; b++) read_chk(b * 1024 + 9 * r, "R5 R11 erase");
        end

        // R6 R7: suspend then resume.
        @(negedge clk);
        erase_sel = 4'b0101; op_error = 0; erase_live = 1;
        start_op();
        read_chk(0, "R1 erase before suspend");
        read_chk(2048, "R5 erase before suspend");
        read_chk(1024, "R5 other block");
        @(negedge clk); op_busy = 0; erase_susp = 1;
        for (int b = 0; b < NBLK; b++) read_chk(b * 1024 + 3, "R6 suspend");
        read_chk(2048 + 1, "R6 suspend again");
        // program inside suspend
        @(negedge clk); op_busy = 1; op_erase = 0; prog_bit7 = 1;
        for (int b = 0; b < NBLK; b++) read_chk(b * 1024 + 4, "R1 program in suspend");
        @(negedge clk); op_busy = 0; op_erase = 1;
        read_chk(0, "R6 suspend after program");
        @(negedge clk); erase_susp = 0; op_busy = 1;
        read_chk(1024, "R7 resume continues bit 6");
        read_chk(3072, "R7 resume continues bit 6");

        // R8: protected-only erase window.
        @(negedge clk); op_busy = 0; erase_live = 0;
        erase_sel = 4'b0011; blk_prot = 4'b0111;
        start_op(); m_win = 1;
        for (int b = 0; b < NBLK; b++) read_chk(b * 1024 + 6, "R8 window");
        repeat (PC) @(negedge clk);
        m_win = 0;
        for (int b = 0; b < NBLK; b++) read_chk(b * 1024 + 6, "R8 after window");
        // partial protection: no window
        @(negedge clk); blk_prot = 4'b0001;
        start_op();
        read_chk(0, "R8 partial protect no window");
        read_chk(1024, "R8 partial protect no window");

        // R10: no strobe, inputs change, output holds.
        begin
            logic [7:0] held;
            held = dout;
            @(negedge clk); op_busy = 1; array_data = 8'hA5; rd_addr = 12'h400;
            repeat (3) @(negedge clk);
            check(dout, held, "R10 hold");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule